// File: doc/BRIEF.md
# Configurable Half/Full-Word Host Bus Adapter

This block lets a host processor without a transfer clock reach a 32-bit internal register or memory port. The chip-select, read/write and strobe lines are brought into the block's own fast clock through a flop synchronizer. A new access is recognised when chip-select and strobe are both low in that domain. The block then issues a one-cycle internal read or write request and raises a ready line after a fixed count of internal cycles. Ready stays high until the host lets go of the strobe.

A full-word strap picks between two bus widths. With the strap high, every access moves all 32 bits. With it low, the host moves each word as two 16-bit accesses on the low data lanes, and a half-select line says which half is meant. A polarity strap plays two roles. In full-word mode it sets the sense of the read/write line. In half-word mode it sets the sense of the half-select line. An order strap names the half that opens each pair. An opening read fetches the whole word at once, so the closing read returns a coherent copy. An opening write is held back until its partner arrives, and then a single 32-bit write goes out.

Top module: `hba_top`

## Requirements
- R1: In full-word mode, with polarity strap 0, host_rw = 1 is a read and 0 is a write. With polarity strap 1, host_rw = 0 is a read and 1 is a write. Each access produces exactly one internal request carrying all 32 data bits, and a read returns all 32 bits on host_rdata.
- R2: In full-word mode the order strap has no effect on the behaviour.
- R3: In half-word mode, host_rw = 1 is always a read. The upper half (bits 31:16) is selected by host_hsel = 1 under polarity strap 0, and by host_hsel = 0 under polarity strap 1. Data uses bits 15:0 of the host buses, and host_rdata[31:16] reads zero.
- R4: In half-word mode, order strap 1 makes the upper half the opening half. Order strap 0 makes the lower half the opening half.
- R5: A half-word read of the opening half issues one internal read and returns that half. A read of the closing half issues no internal read and returns the other half of the same fetched word, even if memory has changed since.
- R6: A half-word write of the opening half issues no internal write. The following closing-half write issues one internal write of the combined word to the address given with the opening half.
- R7: A closing-half write with no opening half pending issues no internal write. A closing-half read returns the matching half of the word fetched by the last internal read.
- R8: host_rdy rises exactly ACK_DLY+3 clock edges after the edge before which the host lowered the strobe. It falls on the third edge after the strobe is raised.
- R9: Reset drops a pending opening write, so the next closing-half write issues nothing. Reset also clears the fetched word to zero, and all outputs read zero after reset.
- R10: While host_cs_n is high, strobe activity produces no internal request and no ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal clock |
| rst | input | 1 | synchronous active-high reset |
| mode32 | input | 1 | strap: 1 = full-word, 0 = half-word |
| pol_strap | input | 1 | strap: read/write sense (full) or half-select sense (half) |
| order_strap | input | 1 | strap: 1 = upper half opens a pair |
| host_cs_n | input | 1 | host chip select, active low |
| host_rw | input | 1 | host direction line |
| host_strb_n | input | 1 | host transfer strobe, active low |
| host_hsel | input | 1 | host half-select line |
| host_addr | input | AW | host word address |
| host_wdata | input | DW | host write data |
| host_rdata | output | DW | host read data, valid while host_rdy is high |
| host_rdy | output | 1 | ready to host |
| int_rd | output | 1 | internal read request, one cycle |
| int_wr | output | 1 | internal write request, one cycle |
| int_addr | output | AW | internal address |
| int_wdata | output | DW | internal write data |
| int_rdata | input | DW | internal read data, one cycle after int_rd |

## Verification
A stale or missing pending-write flag shows up as a wrong count of int_wr pulses. It is visible at the closing-half write, about three cycles after that strobe is detected. A wrong fetched word, or a wrong choice of half, shows on host_rdata by the time host_rdy rises for the closing-half read. The bench changes the memory between the two reads so that a second internal fetch cannot go unnoticed. A wrong ready counter shows as a wrong edge count between the strobe falling and ready rising.

// File: rtl/hba_pkg.sv
package hba_pkg;

  typedef struct packed {
    logic is_rd;   // access reads
    logic upper;   // half-word access targets bits 31:16
    logic first;   // half-word access is the opening half of a pair
  } hba_acc_t;

  function automatic hba_acc_t hba_decode(input logic m32, input logic pol,
                                          input logic order, input logic rw,
                                          input logic hsel);
    hba_acc_t a;
    a.is_rd = m32 ? (rw ^ pol) : rw;
    a.upper = hsel ^ pol;
    a.first = (a.upper == order);
    return a;
  endfunction

endpackage

// File: rtl/hba_front.sv
module hba_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rw,
  input  logic strb_n,
  output logic rw_s,
  output logic act,
  output logic start
);
  localparam int W = 3;
  localparam logic [W-1:0] IDLE_VAL = 3'b101;

  logic [W-1:0] pipe [STAGES];
  logic act_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= IDLE_VAL;
          else     pipe[0] <= {cs_n, rw, strb_n};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= IDLE_VAL;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign rw_s  = pipe[STAGES-1][1];
  assign act   = ~pipe[STAGES-1][2] & ~pipe[STAGES-1][0];
  assign start = act & ~act_d;

  always_ff @(posedge clk) begin
    if (rst) act_d <= 1'b0;
    else     act_d <= act;
  end

  // R8
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

endmodule

// File: rtl/hba_ack.sv
module hba_ack #(
  parameter int ACK_DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  output logic rdy
);
  localparam int CW = $clog2(ACK_DLY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(ACK_DLY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !act) begin
      cnt <= '0;
      rdy <= 1'b0;
    end else if (cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end else begin
      rdy <= 1'b1;
    end
  end

  // R8
  rdy_release_chk: assert property (@(posedge clk) disable iff (rst)
    !act |=> !rdy);

  // R8
  rdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy) |-> ($past(act) && $past(act, 2)));

endmodule

// File: rtl/hba_seq.sv
module hba_seq
  import hba_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode32,
  input  logic          pol,
  input  logic          order,
  input  logic          start,
  input  logic          rw_s,
  input  logic          hsel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] int_rdata,
  output logic          int_rd,
  output logic          int_wr,
  output logic [AW-1:0] int_addr,
  output logic [DW-1:0] int_wdata,
  output logic [DW-1:0] host_rdata
);
  localparam int HW = DW / 2;

  hba_acc_t      acc;
  logic [HW-1:0] wd;
  logic          cap_q;
  logic          pend_upper;
  logic [DW-1:0] rd_latch;
  logic [DW-1:0] stage;
  logic          wr_armed;
  logic [AW-1:0] wr_addr;

  assign acc = hba_decode(mode32, pol, order, rw_s, hsel);
  assign wd  = wdata[HW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      int_rd     <= 1'b0;
      int_wr     <= 1'b0;
      int_addr   <= '0;
      int_wdata  <= '0;
      host_rdata <= '0;
      cap_q      <= 1'b0;
      pend_upper <= 1'b0;
      rd_latch   <= '0;
      stage      <= '0;
      wr_armed   <= 1'b0;
      wr_addr    <= '0;
    end else begin
      int_rd <= 1'b0;
      int_wr <= 1'b0;
      cap_q  <= int_rd;
      if (cap_q) begin
        rd_latch <= int_rdata;
        if (mode32)          host_rdata <= int_rdata;
        else if (pend_upper) host_rdata <= {{HW{1'b0}}, int_rdata[DW-1:HW]};
        else                 host_rdata <= {{HW{1'b0}}, int_rdata[HW-1:0]};
      end
      if (start) begin
        if (mode32) begin
          int_addr <= addr;
          if (acc.is_rd) begin
            int_rd <= 1'b1;
          end else begin
            int_wr    <= 1'b1;
            int_wdata <= wdata;
          end
        end else if (acc.is_rd) begin
          if (acc.first) begin
            int_rd     <= 1'b1;
            int_addr   <= addr;
            pend_upper <= acc.upper;
          end else if (acc.upper) begin
            host_rdata <= {{HW{1'b0}}, rd_latch[DW-1:HW]};
          end else begin
            host_rdata <= {{HW{1'b0}}, rd_latch[HW-1:0]};
          end
        end else if (acc.first) begin
          if (acc.upper) stage[DW-1:HW] <= wd;
          else           stage[HW-1:0]  <= wd;
          wr_armed <= 1'b1;
          wr_addr  <= addr;
        end else if (wr_armed) begin
          int_wr    <= 1'b1;
          int_addr  <= wr_addr;
          int_wdata <= acc.upper ? {wd, stage[HW-1:0]} : {stage[DW-1:HW], wd};
          wr_armed  <= 1'b0;
        end
      end
    end
  end

  // R1
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({int_rd, int_wr}));

  // R1
  wr_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    int_wr |-> $past(start));

  // R5
  rd_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    int_rd |-> $past(start));

  // R6
  half_wr_armed_chk: assert property (@(posedge clk) disable iff (rst)
    (int_wr && !mode32) |-> $past(wr_armed));

endmodule

// File: rtl/hba_top.sv
module hba_top #(
  parameter int AW      = 4,
  parameter int DW      = 32,
  parameter int STAGES  = 2,
  parameter int ACK_DLY = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode32,
  input  logic          pol_strap,
  input  logic          order_strap,
  input  logic          host_cs_n,
  input  logic          host_rw,
  input  logic          host_strb_n,
  input  logic          host_hsel,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdy,
  output logic          int_rd,
  output logic          int_wr,
  output logic [AW-1:0] int_addr,
  output logic [DW-1:0] int_wdata,
  input  logic [DW-1:0] int_rdata
);
  logic rw_s;
  logic act;
  logic start;

  hba_front #(.STAGES(STAGES)) u_front (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (host_cs_n),
    .rw     (host_rw),
    .strb_n (host_strb_n),
    .rw_s   (rw_s),
    .act    (act),
    .start  (start)
  );

  hba_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .mode32     (mode32),
    .pol        (pol_strap),
    .order      (order_strap),
    .start      (start),
    .rw_s       (rw_s),
    .hsel       (host_hsel),
    .addr       (host_addr),
    .wdata      (host_wdata),
    .int_rdata  (int_rdata),
    .int_rd     (int_rd),
    .int_wr     (int_wr),
    .int_addr   (int_addr),
    .int_wdata  (int_wdata),
    .host_rdata (host_rdata)
  );

  hba_ack #(.ACK_DLY(ACK_DLY)) u_ack (
    .clk (clk),
    .rst (rst),
    .act (act),
    .rdy (host_rdy)
  );

  // R10
  no_req_without_cs_chk: assert property (@(posedge clk) disable iff (rst)
    (int_rd || int_wr) |-> $past(act));

endmodule

// File: tb/hba_top_tb.sv
module hba_top_tb;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int ACK_DLY = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode32 = 1'b1, pol_strap = 1'b0, order_strap = 1'b1;
  logic          host_cs_n = 1'b1, host_rw = 1'b0, host_strb_n = 1'b1, host_hsel = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          host_rdy, int_rd, int_wr;
  logic [AW-1:0] int_addr;
  logic [DW-1:0] int_wdata;
  logic [DW-1:0] int_rdata = '0;

  logic [DW-1:0] mem [1 << AW];
  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [DW-1:0] last_word = '0;
  bit done = 0;

  always #2 clk = ~clk;

  hba_top #(.AW(AW), .DW(DW), .ACK_DLY(ACK_DLY)) u_dut (
    .clk(clk), .rst(rst), .mode32(mode32), .pol_strap(pol_strap),
    .order_strap(order_strap), .host_cs_n(host_cs_n), .host_rw(host_rw),
    .host_strb_n(host_strb_n), .host_hsel(host_hsel), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rdy(host_rdy),
    .int_rd(int_rd), .int_wr(int_wr), .int_addr(int_addr),
    .int_wdata(int_wdata), .int_rdata(int_rdata)
  );

  // memory model with one-cycle read latency
  always @(posedge clk) begin
    if (int_wr) begin
      mem[int_addr] <= int_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (int_rd) begin
      int_rdata <= mem[int_addr];
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic rw, input logic hsel, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] rd,
                        output int lat, output int rel);
    @(negedge clk);
    host_cs_n = 1'b0; host_rw = rw; host_hsel = hsel; host_addr = a;
    host_wdata = d; host_strb_n = 1'b0;
    lat = 0;
    while (!host_rdy && lat < 100) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    rd = host_rdata;
    host_strb_n = 1'b1; host_cs_n = 1'b1;
    rel = 0;
    while (host_rdy && rel < 100) begin
      @(posedge clk); rel++; @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    last_word = '0;
  endtask

  task automatic t_reset_state();
    chk("R9 rdy after reset", {31'b0, host_rdy}, 0);
    chk("R9 requests after reset", {30'b0, int_rd, int_wr}, 0);
    chk("R9 rdata after reset", host_rdata, 0);
  endtask

  task automatic t_full(input logic pol, input logic order, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
    logic [DW-1:0] r; int lat, rel, w0, r0;
    mode32 = 1'b1; pol_strap = pol; order_strap = order;
    w0 = wr_cnt; r0 = rd_cnt;
    access(pol, 1'b0, a, d, r, lat, rel);   // write: rw equals pol
    chk("R1 full write count", wr_cnt - w0, 1);
    chk("R1 full write no read", rd_cnt - r0, 0);
    chk(order ? "R1 full write data" : "R2 order ignored write", mem[a], d);
    access(~pol, 1'b0, a, '0, r, lat, rel); // read: rw equals ~pol
    last_word = d;
    chk(order ? "R1 full read data" : "R2 order ignored read", r, d);
    chk("R1 full read count", rd_cnt - r0, 1);
  endtask

  task automatic t_half_read(input logic pol, input logic order, input logic [AW-1:0] a,
                             input logic [DW-1:0] w);
    logic [DW-1:0] r; int lat, rel, r0;
    mode32 = 1'b0; pol_strap = pol; order_strap = order;
    @(negedge clk); mem[a] = w;
    r0 = rd_cnt;
    access(1'b1, order ^ pol, a, '0, r, lat, rel);
    chk("R4 opening half read", r, order ? {16'h0, w[31:16]} : {16'h0, w[15:0]});
    @(negedge clk); mem[a] = ~w;
    access(1'b1, ~order ^ pol, a, '0, r, lat, rel);
    chk("R5 coherent closing half", r, order ? {16'h0, w[15:0]} : {16'h0, w[31:16]});
    chk("R5 single internal read", rd_cnt - r0, 1);
    last_word = w;
  endtask

  task automatic t_half_write(input logic pol, input logic order, input logic [AW-1:0] a1,
                              input logic [AW-1:0] a2, input logic [15:0] d1,
                              input logic [15:0] d2);
    logic [DW-1:0] r; int lat, rel, w0;
    mode32 = 1'b0; pol_strap = pol; order_strap = order;
    @(negedge clk); mem[a1] = 32'hDEAD_0001; mem[a2] = 32'hDEAD_0002;
    w0 = wr_cnt;
    access(1'b0, order ^ pol, a1, {16'hFFFF, d1}, r, lat, rel);
    chk("R6 opening write held", wr_cnt - w0, 0);
    access(1'b0, ~order ^ pol, a2, {16'hFFFF, d2}, r, lat, rel);
    chk("R6 one combined write", wr_cnt - w0, 1);
    chk("R3 R6 combined word", mem[a1], order ? {d1, d2} : {d2, d1});
    chk("R6 second address untouched", mem[a2], 32'hDEAD_0002);
  endtask

  task automatic t_orphan();
    logic [DW-1:0] r; int lat, rel, w0, r0;
    mode32 = 1'b0; pol_strap = 1'b1; order_strap = 1'b0;
    w0 = wr_cnt; r0 = rd_cnt;
    access(1'b0, 1'b0, 4'd9, 32'h0000_7777, r, lat, rel); // upper = closing half
    chk("R7 orphan write dropped", wr_cnt - w0, 0);
    access(1'b1, 1'b0, 4'd9, '0, r, lat, rel);
    chk("R7 orphan read from latch", r, {16'h0, last_word[31:16]});
    chk("R7 orphan no fetch", rd_cnt - r0, 0);
  endtask

  task automatic t_timing();
    logic [DW-1:0] r; int lat, rel;
    mode32 = 1'b1; pol_strap = 1'b0;
    access(1'b1, 1'b0, 4'd1, '0, r, lat, rel);
    chk("R8 ready latency", lat, ACK_DLY + 3);
    chk("R8 release latency", rel, 3);
  endtask

  task automatic t_no_cs();
    int w0, r0, seen;
    w0 = wr_cnt; r0 = rd_cnt; seen = 0;
    @(negedge clk); host_cs_n = 1'b1; host_rw = 1'b0; host_strb_n = 1'b0;
    repeat (12) begin @(negedge clk); if (host_rdy) seen++; end
    host_strb_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 no ready without select", seen, 0);
    chk("R10 no request without select", (wr_cnt - w0) + (rd_cnt - r0), 0);
  endtask

  task automatic t_reset_mid();
    logic [DW-1:0] r; int lat, rel, w0;
    mode32 = 1'b0; pol_strap = 1'b0; order_strap = 1'b1;
    w0 = wr_cnt;
    access(1'b0, 1'b1, 4'd3, 32'h0000_1234, r, lat, rel);
    do_reset();
    access(1'b0, 1'b0, 4'd3, 32'h0000_5678, r, lat, rel);
    chk("R9 pending write dropped by reset", wr_cnt - w0, 0);
    access(1'b1, 1'b0, 4'd3, '0, r, lat, rel);
    chk("R9 latch cleared by reset", r, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_full(1'b0, 1'b1, 4'd2, 32'hA5A5_1234);
    t_full(1'b1, 1'b1, 4'd4, 32'h0F0F_C3C3);
    t_full(1'b0, 1'b0, 4'd6, 32'h1357_9BDF);
    t_half_read(1'b0, 1'b1, 4'd5, 32'hCAFE_BEEF);
    t_half_read(1'b1, 1'b0, 4'd7, 32'h1122_3344);
    t_half_write(1'b0, 1'b1, 4'd10, 4'd11, 16'hAAAA, 16'h5555);
    t_half_write(1'b1, 1'b0, 4'd12, 4'd13, 16'h0123, 16'h4567);
    t_orphan();
    t_timing();
    t_no_cs();
    t_reset_mid();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule